// File: doc/BRIEF.md
# Interrupt Line Status and Request Routing Stage

This block is the status stage of an interrupt controller. It watches a set of interrupt input lines (32 by default). For each line it applies a programmable polarity and then reports either the live level or a captured edge. The per-line result is gated by an enable and sent to one of two request classes: a normal request and a fast request. For each class the block registers a request flag and the number of the lowest pending line.

Software configures the stage through a small word-addressed register port. Writes take effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. There is no streaming data path, so every pin is a plain control or status signal with no back-pressure. An 8-bit pending mask for the processor carries both requests at fixed bit positions.

Top module: `irq_status_stage`

## Requirements
- R1: The raw status of line i is `line_in[i] XOR NOT keep[i]`, where keep is register address 0. A keep bit of 0 reports the line inverted. The raw status reads back at address 5.
- R2: When a line's raw status is 1 in a cycle and was 0 in the cycle before, its sticky bit is 1 from the next clock edge. Sticky bits read back at address 4.
- R3: The final status of line i is the sticky view when latch-select bit i (address 1) is 1, and the raw status otherwise. The sticky view is the stored sticky bit OR a rise detected in the current cycle. The final status reads back at address 6.
- R4: Writing address 4 clears every sticky bit whose write-data bit is 1 and leaves the bits written 0 unchanged. A rise in the same cycle as a clear sets the bit.
- R5: Line i is pending when its final status and its enable bit (address 2) are both 1. Class bit i (address 3) selects the fast class when 1 and the normal class when 0. Address 7 reads the enabled final status, final AND enable.
- R6: `irq_req` and `fiq_req` are registered. Each equals, one cycle later, whether any line is pending in the normal class or the fast class respectively.
- R7: `irq_id` and `fiq_id` are registered alongside the requests. Each holds the lowest-numbered line pending in its class, and 0 when that class has none.
- R8: `cpu_pend[7]` equals `irq_req`, `cpu_pend[6]` equals `fiq_req`, and `cpu_pend[5:0]` are 0.
- R9: After reset, keep is all ones. Latch-select, enable, class, sticky and the stored previous raw status are all zero, and both requests and both identifiers are 0.
- R10: Addresses 0 to 3 (keep, latch-select, enable, class) read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | N | Interrupt input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address for write and read |
| reg_wdata | input | N | Register write data |
| reg_rdata | output | N | Register read data, combinational from reg_addr |
| irq_req | output | 1 | Normal-class request, registered |
| fiq_req | output | 1 | Fast-class request, registered |
| irq_id | output | log2(N) | Lowest pending normal-class line |
| fiq_id | output | log2(N) | Lowest pending fast-class line |
| cpu_pend | output | 8 | Processor pending mask, normal at bit 7 and fast at bit 6 |

## Verification
On every cycle the assertions check four things. A detected rise always lands in the sticky register. A sticky bit that is neither cleared nor re-set never drops, and a clear without a concurrent rise takes effect. Each request equals the previous cycle's pending vector for its class, and each identifier points at a pending line with no lower pending line in that class. Polarity inversion, the choice between level and latched views, register read-back, and the reset values can only be shown by the bench's scenarios. Those scenarios walk every line through each configuration, and the bench compares the design against its own model on every cycle.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int ADDR_W      = 3;
  localparam int CPU_PEND_W  = 8;
  localparam int CPU_IRQ_BIT = 7;
  localparam int CPU_FIQ_BIT = 6;
  localparam int NUM_CLASSES = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_KEEP   = 3'd0,
    RA_LATCH  = 3'd1,
    RA_ENABLE = 3'd2,
    RA_CLASS  = 3'd3,
    RA_STICKY = 3'd4,
    RA_RAW    = 3'd5,
    RA_FINAL  = 3'd6,
    RA_PEND   = 3'd7
  } reg_addr_e;

  typedef enum int {
    CLS_NORMAL = 0,
    CLS_FAST   = 1
  } irq_class_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_status_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      keep_q,
  output logic [N-1:0]      latch_q,
  output logic [N-1:0]      enable_q,
  output logic [N-1:0]      class_q,
  output logic [N-1:0]      clr_mask
);

  reg_addr_e sel_addr;
  assign sel_addr = reg_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q   <= '1;
      latch_q  <= '0;
      enable_q <= '0;
      class_q  <= '0;
    end else if (wr_en) begin
      case (sel_addr)
        RA_KEEP:   keep_q   <= wdata;
        RA_LATCH:  latch_q  <= wdata;
        RA_ENABLE: enable_q <= wdata;
        RA_CLASS:  class_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_mask = '0;
    if (wr_en && sel_addr == RA_STICKY) clr_mask = wdata;
  end

endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] keep,
  input  logic [N-1:0] latch_sel,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] raw_st,
  output logic [N-1:0] sticky_q,
  output logic [N-1:0] final_st
);

  logic [N-1:0] prev_q;
  logic [N-1:0] rise;
  logic [N-1:0] sticky_d;
  logic [N-1:0] view;

  assign raw_st   = line_in ^ ~keep;
  assign rise     = raw_st & ~prev_q;
  assign sticky_d = (sticky_q & ~clr_mask) | rise;
  assign view     = sticky_q | rise;

  for (genvar g = 0; g < N; g++) begin : gen_line
    assign final_st[g] = latch_sel[g] ? view[g] : raw_st[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      sticky_q <= '0;
    end else begin
      prev_q   <= raw_st;
      sticky_q <= sticky_d;
    end
  end

endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int N   = 32,
  parameter int IDW = 5
) (
  input  logic [N-1:0]   vec,
  output logic           valid,
  output logic [IDW-1:0] id
);

  always_comb begin
    valid = |vec;
    id    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) id = IDW'(i);
    end
  end

endmodule

// File: rtl/irq_class_route.sv
module irq_class_route
  import irq_status_pkg::*;
#(
  parameter int N   = 32,
  parameter int IDW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   final_st,
  input  logic [N-1:0]   enable,
  input  logic [N-1:0]   cls_sel,
  output logic           irq_req,
  output logic           fiq_req,
  output logic [IDW-1:0] irq_id,
  output logic [IDW-1:0] fiq_id
);

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : gen_cls
    logic [N-1:0]   pend;
    logic           vld_d;
    logic [IDW-1:0] id_d;
    logic           vld_q;
    logic [IDW-1:0] id_q;

    if (c == CLS_FAST) begin : gen_fast
      assign pend = final_st & enable & cls_sel;
    end else begin : gen_norm
      assign pend = final_st & enable & ~cls_sel;
    end

    irq_lowest_enc #(.N(N), .IDW(IDW)) u_enc (
      .vec   (pend),
      .valid (vld_d),
      .id    (id_d)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        id_q  <= '0;
      end else begin
        vld_q <= vld_d;
        id_q  <= id_d;
      end
    end
  end

  assign irq_req = gen_cls[CLS_NORMAL].vld_q;
  assign irq_id  = gen_cls[CLS_NORMAL].id_q;
  assign fiq_req = gen_cls[CLS_FAST].vld_q;
  assign fiq_id  = gen_cls[CLS_FAST].id_q;

endmodule

// File: rtl/irq_status_stage.sv
module irq_status_stage
  import irq_status_pkg::*;
#(
  parameter  int N   = 32,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          line_in,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [N-1:0]          reg_wdata,
  output logic [N-1:0]          reg_rdata,
  output logic                  irq_req,
  output logic                  fiq_req,
  output logic [IDW-1:0]        irq_id,
  output logic [IDW-1:0]        fiq_id,
  output logic [CPU_PEND_W-1:0] cpu_pend
);

  logic [N-1:0] keep_q, latch_q, enable_q, class_q, clr_mask;
  logic [N-1:0] raw_st, sticky_q, final_st;

  irq_cfg_regs #(.N(N)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .keep_q   (keep_q),
    .latch_q  (latch_q),
    .enable_q (enable_q),
    .class_q  (class_q),
    .clr_mask (clr_mask)
  );

  irq_edge_latch #(.N(N)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .keep      (keep_q),
    .latch_sel (latch_q),
    .clr_mask  (clr_mask),
    .raw_st    (raw_st),
    .sticky_q  (sticky_q),
    .final_st  (final_st)
  );

  irq_class_route #(.N(N), .IDW(IDW)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .final_st (final_st),
    .enable   (enable_q),
    .cls_sel  (class_q),
    .irq_req  (irq_req),
    .fiq_req  (fiq_req),
    .irq_id   (irq_id),
    .fiq_id   (fiq_id)
  );

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_KEEP:   reg_rdata = keep_q;
      RA_LATCH:  reg_rdata = latch_q;
      RA_ENABLE: reg_rdata = enable_q;
      RA_CLASS:  reg_rdata = class_q;
      RA_STICKY: reg_rdata = sticky_q;
      RA_RAW:    reg_rdata = raw_st;
      RA_FINAL:  reg_rdata = final_st;
      default:   reg_rdata = final_st & enable_q;
    endcase
  end

  always_comb begin
    cpu_pend              = '0;
    cpu_pend[CPU_IRQ_BIT] = irq_req;
    cpu_pend[CPU_FIQ_BIT] = fiq_req;
  end

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
#(
  parameter int N   = 32,
  parameter int IDW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [N-1:0]      reg_wdata,
  input logic [N-1:0]      raw_st,
  input logic [N-1:0]      sticky_q,
  input logic [N-1:0]      final_st,
  input logic [N-1:0]      enable_q,
  input logic [N-1:0]      class_q,
  input logic              irq_req,
  input logic              fiq_req,
  input logic [IDW-1:0]    irq_id,
  input logic [IDW-1:0]    fiq_id
);

  logic [N-1:0] raw_d;
  logic [N-1:0] rise_c, clr_c, pend_n, pend_f;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_d <= '0;
    else        raw_d <= raw_st;
  end

  assign rise_c = raw_st & ~raw_d;
  assign clr_c  = (reg_wr && reg_addr == RA_STICKY) ? reg_wdata : '0;
  assign pend_n = final_st & enable_q & ~class_q;
  assign pend_f = final_st & enable_q & class_q;

  a_r2_rise_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_c != '0) |=> (($past(rise_c) & ~sticky_q) == '0));

  a_r4_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sticky_q & ~clr_c) & ~sticky_q) == '0));

  a_r4_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_c != '0) |=> (($past(clr_c & ~rise_c) & sticky_q) == '0));

  a_r6_irq_req: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_req == $past(pend_n != '0)));

  a_r6_fiq_req: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fiq_req == $past(pend_f != '0)));

  a_r7_irq_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!irq_req ||
              ((($past(pend_n) >> irq_id) & N'(1)) == N'(1) &&
               ($past(pend_n) & ((N'(1) << irq_id) - N'(1))) == '0)));

  a_r7_fiq_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!fiq_req ||
              ((($past(pend_f) >> fiq_id) & N'(1)) == N'(1) &&
               ($past(pend_f) & ((N'(1) << fiq_id) - N'(1))) == '0)));

endmodule

bind irq_status_stage irq_status_chk #(.N(N), .IDW(IDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .raw_st    (raw_st),
  .sticky_q  (sticky_q),
  .final_st  (final_st),
  .enable_q  (enable_q),
  .class_q   (class_q),
  .irq_req   (irq_req),
  .fiq_req   (fiq_req),
  .irq_id    (irq_id),
  .fiq_id    (fiq_id)
);

// File: tb/irq_status_stage_tb.sv
module irq_status_stage_tb;
  localparam int N   = 32;
  localparam int IDW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]   line_in = '0;
  logic           reg_wr = 1'b0;
  logic [2:0]     reg_addr = '0;
  logic [N-1:0]   reg_wdata = '0;
  logic [N-1:0]   reg_rdata;
  logic           irq_req, fiq_req;
  logic [IDW-1:0] irq_id, fiq_id;
  logic [7:0]     cpu_pend;

  irq_status_stage #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req), .irq_id(irq_id),
    .fiq_id(fiq_id), .cpu_pend(cpu_pend)
  );

  int checks = 0;
  int fails  = 0;

  logic [N-1:0]   m_keep, m_sel, m_en, m_cls, m_sticky, m_prev;
  logic           m_irq, m_fiq;
  logic [IDW-1:0] m_iid, m_fid;

  function automatic logic [IDW-1:0] lowest(logic [N-1:0] v);
    lowest = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) lowest = IDW'(i);
  endfunction

  function automatic logic [N-1:0] f_raw();
    return line_in ^ ~m_keep;
  endfunction

  function automatic logic [N-1:0] f_final();
    logic [N-1:0] r;
    r = f_raw();
    return (m_sel & (m_sticky | (r & ~m_prev))) | (~m_sel & r);
  endfunction

  function automatic logic [N-1:0] f_read(logic [2:0] a);
    case (a)
      3'd0: return m_keep;
      3'd1: return m_sel;
      3'd2: return m_en;
      3'd3: return m_cls;
      3'd4: return m_sticky;
      3'd5: return f_raw();
      3'd6: return f_final();
      default: return f_final() & m_en;
    endcase
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    check("R6 irq_req", N'(irq_req), N'(m_irq));
    check("R6 fiq_req", N'(fiq_req), N'(m_fiq));
    check("R7 irq_id", N'(irq_id), N'(m_iid));
    check("R7 fiq_id", N'(fiq_id), N'(m_fid));
    check("R8 cpu_pend", N'(cpu_pend), N'({m_irq, m_fiq, 6'b0}));
  endtask

  task automatic check_rd(logic [2:0] a, string tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, f_read(a));
  endtask

  task automatic cyc(logic wr, logic [2:0] a, logic [N-1:0] d);
    logic [N-1:0] raw, fin, pn, pf, clr, nst;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    #2;
    raw = f_raw();
    fin = f_final();
    pn  = fin & m_en & ~m_cls;
    pf  = fin & m_en & m_cls;
    clr = (wr && a == 3'd4) ? d : '0;
    nst = (m_sticky & ~clr) | (raw & ~m_prev);
    @(posedge clk); #1;
    m_prev = raw; m_sticky = nst;
    m_irq = |pn; m_fiq = |pf; m_iid = lowest(pn); m_fid = lowest(pf);
    if (wr) begin
      case (a)
        3'd0: m_keep = d;
        3'd1: m_sel  = d;
        3'd2: m_en   = d;
        3'd3: m_cls  = d;
        default: ;
      endcase
    end
    reg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    m_keep = '1; m_sel = '0; m_en = '0; m_cls = '0; m_sticky = '0; m_prev = '0;
    m_irq = 1'b0; m_fiq = 1'b0; m_iid = '0; m_fid = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: reset state
    check_outs();
    for (int a = 0; a < 8; a++) begin
      check_rd(3'(a), "R9 reset read");
      cyc(1'b0, 3'd0, '0);
    end

    // R10: configuration read-back
    for (int a = 0; a < 4; a++) begin
      cyc(1'b1, 3'(a), 32'hA5C3_0F96 ^ (32'h1111_1111 * a));
      check_rd(3'(a), "R10 readback");
    end
    cyc(1'b1, 3'd0, '1); cyc(1'b1, 3'd1, '0);
    cyc(1'b1, 3'd2, '0); cyc(1'b1, 3'd3, '0);
    cyc(1'b1, 3'd4, '1);

    // R1: polarity sweep over every line
    for (int i = 0; i < N; i++) begin
      line_in = N'(1) << ((i * 5) % N);
      cyc(1'b1, 3'd0, ~(N'(1) << i));
      check_rd(3'd5, "R1 raw");
      check_outs();
    end
    cyc(1'b1, 3'd0, '1);
    line_in = '0;
    cyc(1'b0, 3'd0, '0);

    // R3, R5, R6, R7: level mode, class split, lowest-first
    cyc(1'b1, 3'd2, '1);
    cyc(1'b1, 3'd3, 32'h5555_0F0F);
    for (int k = 0; k < N; k++) begin
      line_in = '1 << k;
      cyc(1'b0, 3'd0, '0);
      check_outs();
      check_rd(3'd6, "R3 final level");
      cyc(1'b0, 3'd0, '0);
      check_outs();
      check_rd(3'd7, "R5 pending");
    end
    cyc(1'b1, 3'd2, 32'hF0F0_3C3C);
    check_rd(3'd7, "R5 enable mask");
    cyc(1'b0, 3'd0, '0);
    check_outs();
    line_in = '0;
    cyc(1'b1, 3'd2, '1);

    // R2, R3: latched mode, single-cycle pulses per line
    cyc(1'b1, 3'd1, '1);
    cyc(1'b1, 3'd4, '1);
    check_rd(3'd4, "R4 clear all");
    for (int i = N - 1; i >= 0; i--) begin
      line_in = N'(1) << i;
      cyc(1'b0, 3'd0, '0);
      check_outs();
      line_in = '0;
      cyc(1'b0, 3'd0, '0);
      check_rd(3'd4, "R2 sticky");
      check_outs();
      check_rd(3'd6, "R3 final latched");
    end

    // R4: clear with concurrent rise, zero-write, full clear
    line_in = (N'(1) << 3) | (N'(1) << 20);
    cyc(1'b1, 3'd4, 32'h0000_FFFF);
    check_rd(3'd4, "R4 set wins");
    check_outs();
    cyc(1'b1, 3'd4, '0);
    check_rd(3'd4, "R4 zero write");
    line_in = '0;
    cyc(1'b1, 3'd4, '1);
    check_rd(3'd4, "R4 clear");
    cyc(1'b0, 3'd0, '0);
    check_outs();

    // R1 with R2: inverted line in latched mode
    cyc(1'b1, 3'd0, ~(N'(1) << 9));
    cyc(1'b0, 3'd0, '0);
    check_rd(3'd4, "R2 inverted rise");
    check_outs();

    summary();
    $finish;
  end

endmodule